// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the exception status of a floating-point unit. After each operation, the arithmetic datapath presents five raw exception indications with a valid strobe. The unit then rewrites two five-bit fields of the control/status register. The sticky-free flags field records every condition that was raised. The cause field records only the raised conditions whose enable bit is set in the register's enable field. A trap request follows the cause field one cycle later, so the pipeline can take a floating-point exception.

Software can load the enable, flags and cause fields directly through a write port. A software write wins over an operation update that arrives in the same cycle. A global reporting switch forces both fields to zero on the next operation while it is off. The arithmetic itself and rounding are handled elsewhere.

The register update is chosen each cycle by an update selector with four named cases:
- UPD_HOLD: no strobe and no write.
- UPD_SOFT: a software write.
- UPD_OP_REPORT: an operation with reporting on.
- UPD_OP_MUTE: an operation with reporting off.

The trap logic is a two-state machine. In TRAP_QUIET no trap is requested; it moves to TRAP_RAISED when the registered cause field is nonzero. In TRAP_RAISED a trap is requested; it returns to TRAP_QUIET when the cause field reads zero.

Top module: `fpx_status_unit`

## Requirements
- R1: While reset is held and after its release, flags_q, cause_q, enable_q and trap_req are all zero until the first update.
- R2: An operation (op_valid=1, sw_wr=0) with report_en=1 makes flags_q equal to exc_raw after that clock edge, for every raised bit regardless of enable_q.
- R3: An operation with report_en=1 makes cause_q equal to exc_raw AND enable_q after that clock edge.
- R4: Each operation overwrites flags_q and cause_q rather than OR-ing into their old values.
- R5: An operation with report_en=0 clears both flags_q and cause_q to zero.
- R6: trap_req is 1 in the cycle after cause_q is nonzero, and 0 in the cycle after cause_q is zero.
- R7: A software write (sw_wr=1) loads enable_q, flags_q and cause_q from sw_enable, sw_flags and sw_cause; enable_q changes only through this write.
- R8: When sw_wr and op_valid are both 1 in the same cycle, the software values are loaded and the operation is ignored.
- R9: With op_valid=0 and sw_wr=0, flags_q, cause_q and enable_q keep their values.
- R10: Bit positions are the same in all five-bit fields: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation result strobe from the datapath |
| exc_raw | input | 5 | Raw exception indications of the operation |
| report_en | input | 1 | Global exception reporting switch |
| sw_wr | input | 1 | Software write strobe |
| sw_enable | input | 5 | Enable field value to load |
| sw_flags | input | 5 | Flags field value to load |
| sw_cause | input | 5 | Cause field value to load |
| flags_q | output | 5 | Flags field |
| cause_q | output | 5 | Cause field |
| enable_q | output | 5 | Enable field |
| trap_req | output | 1 | Floating-point trap request |

## Verification
The main function is tried in several ways:
- With all enables cleared, all enables set, and partial enable masks against the same raw patterns. This separates the flags behaviour (independent of enables) from the cause behaviour (masked by them).
- With back-to-back operations carrying different single bits. This tells overwrite apart from accumulation.
- With a lone invalid-operation bit. This pins the bit order.
- With reporting switched off, and with a software write colliding with an operation. These separate the clear path and the priority.
- With long random mixes compared every cycle against a behavioural model. These cover trap timing across cause transitions.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W = 5;
    localparam int EXC_INEXACT   = 0;
    localparam int EXC_UNDERFLOW = 1;
    localparam int EXC_OVERFLOW  = 2;
    localparam int EXC_DIVZERO   = 3;
    localparam int EXC_INVALID   = 4;

    typedef logic [EXC_W-1:0] exc_vec_t;

    typedef enum logic [1:0] {
        UPD_HOLD      = 2'd0,
        UPD_SOFT      = 2'd1,
        UPD_OP_REPORT = 2'd2,
        UPD_OP_MUTE   = 2'd3
    } upd_sel_t;

    typedef enum logic {
        TRAP_QUIET  = 1'b0,
        TRAP_RAISED = 1'b1
    } trap_state_t;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int W = EXC_W
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] enable,
    input  logic         report,
    output logic [W-1:0] new_flags,
    output logic [W-1:0] new_cause
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            new_flags[i] = report & raw[i];
            new_cause[i] = report & raw[i] & enable[i];
        end
    end
endmodule

// File: rtl/fpx_csr_reg.sv
module fpx_csr_reg
    import fpx_pkg::*;
#(
    parameter int W = EXC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upd_sel_t     sel,
    input  logic [W-1:0] sw_enable,
    input  logic [W-1:0] sw_flags,
    input  logic [W-1:0] sw_cause,
    input  logic [W-1:0] new_flags,
    input  logic [W-1:0] new_cause,
    output logic [W-1:0] flags_q,
    output logic [W-1:0] cause_q,
    output logic [W-1:0] enable_q
);
    logic [W-1:0] flags_d, cause_d, enable_d;

    always_comb begin
        flags_d  = flags_q;
        cause_d  = cause_q;
        enable_d = enable_q;
        unique case (sel)
            UPD_HOLD: begin
            end
            UPD_SOFT: begin
                flags_d  = sw_flags;
                cause_d  = sw_cause;
                enable_d = sw_enable;
            end
            UPD_OP_REPORT: begin
                flags_d = new_flags;
                cause_d = new_cause;
            end
            UPD_OP_MUTE: begin
                flags_d = '0;
                cause_d = '0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q  <= '0;
            cause_q  <= '0;
            enable_q <= '0;
        end else begin
            flags_q  <= flags_d;
            cause_q  <= cause_d;
            enable_q <= enable_d;
        end
    end
endmodule

// File: rtl/fpx_trap_fsm.sv
module fpx_trap_fsm
    import fpx_pkg::*;
#(
    parameter int W = EXC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_q,
    output logic         trap_req
);
    trap_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRAP_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRAP_QUIET:  if (cause_q != '0) state_d = TRAP_RAISED;
            TRAP_RAISED: if (cause_q == '0) state_d = TRAP_QUIET;
            default:     state_d = TRAP_QUIET;
        endcase
    end

    always_comb begin
        trap_req = (state_q == TRAP_RAISED);
    end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [EXC_W-1:0] exc_raw,
    input  logic             report_en,
    input  logic             sw_wr,
    input  logic [EXC_W-1:0] sw_enable,
    input  logic [EXC_W-1:0] sw_flags,
    input  logic [EXC_W-1:0] sw_cause,
    output logic [EXC_W-1:0] flags_q,
    output logic [EXC_W-1:0] cause_q,
    output logic [EXC_W-1:0] enable_q,
    output logic             trap_req
);
    upd_sel_t     sel;
    logic [EXC_W-1:0] new_flags, new_cause;

    // Software write wins over a same-cycle operation (R8)
    always_comb begin
        if (sw_wr)          sel = UPD_SOFT;
        else if (!op_valid) sel = UPD_HOLD;
        else if (report_en) sel = UPD_OP_REPORT;
        else                sel = UPD_OP_MUTE;
    end

    fpx_classify #(.W(EXC_W)) classify_i (
        .raw       (exc_raw),
        .enable    (enable_q),
        .report    (report_en),
        .new_flags (new_flags),
        .new_cause (new_cause)
    );

    fpx_csr_reg #(.W(EXC_W)) csr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sw_enable (sw_enable),
        .sw_flags  (sw_flags),
        .sw_cause  (sw_cause),
        .new_flags (new_flags),
        .new_cause (new_cause),
        .flags_q   (flags_q),
        .cause_q   (cause_q),
        .enable_q  (enable_q)
    );

    fpx_trap_fsm #(.W(EXC_W)) trap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_q  (cause_q),
        .trap_req (trap_req)
    );
endmodule

// File: rtl/fpx_status_checker.sv
module fpx_status_checker
    import fpx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [EXC_W-1:0] exc_raw,
    input logic             report_en,
    input logic             sw_wr,
    input logic [EXC_W-1:0] sw_enable,
    input logic [EXC_W-1:0] sw_flags,
    input logic [EXC_W-1:0] sw_cause,
    input logic [EXC_W-1:0] flags_q,
    input logic [EXC_W-1:0] cause_q,
    input logic [EXC_W-1:0] enable_q,
    input logic             trap_req
);
    assert_flags_follow_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && report_en) |=> (flags_q == $past(exc_raw)));

    assert_cause_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && report_en) |=> (cause_q == ($past(exc_raw) & $past(enable_q))));

    assert_mute_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !sw_wr && !report_en) |=> (flags_q == '0 && cause_q == '0));

    assert_trap_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != '0) |=> trap_req);

    assert_trap_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0) |=> !trap_req);

    assert_soft_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (flags_q == $past(sw_flags) && cause_q == $past(sw_cause)
                   && enable_q == $past(sw_enable)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !op_valid) |=> ($stable(flags_q) && $stable(cause_q) && $stable(enable_q)));

    assert_enable_only_soft_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> $stable(enable_q));
endmodule

bind fpx_status_unit fpx_status_checker checker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .exc_raw   (exc_raw),
    .report_en (report_en),
    .sw_wr     (sw_wr),
    .sw_enable (sw_enable),
    .sw_flags  (sw_flags),
    .sw_cause  (sw_cause),
    .flags_q   (flags_q),
    .cause_q   (cause_q),
    .enable_q  (enable_q),
    .trap_req  (trap_req)
);

// File: tb/fpx_status_unit_tb_top.sv
module fpx_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] exc_raw = '0;
    logic       report_en = 1'b0;
    logic       sw_wr = 1'b0;
    logic [4:0] sw_enable = '0;
    logic [4:0] sw_flags = '0;
    logic [4:0] sw_cause = '0;
    logic [4:0] flags_q, cause_q, enable_q;
    logic       trap_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [4:0] m_flags = '0, m_cause = '0, m_enable = '0;
    logic       m_trap = 1'b0;

    always #4 clk = ~clk;

    fpx_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .exc_raw(exc_raw),
        .report_en(report_en), .sw_wr(sw_wr), .sw_enable(sw_enable),
        .sw_flags(sw_flags), .sw_cause(sw_cause), .flags_q(flags_q),
        .cause_q(cause_q), .enable_q(enable_q), .trap_req(trap_req)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags <= '0; m_cause <= '0; m_enable <= '0; m_trap <= 1'b0;
        end else begin
            m_trap <= (m_cause != 0);
            if (sw_wr) begin
                m_flags <= sw_flags; m_cause <= sw_cause; m_enable <= sw_enable;
            end else if (op_valid) begin
                if (report_en) begin
                    m_flags <= exc_raw;
                    m_cause <= exc_raw & m_enable;
                end else begin
                    m_flags <= '0; m_cause <= '0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then compare at the following falling edge
    task automatic cyc(input logic op, input logic [4:0] raw, input logic rep,
                       input logic sw, input logic [4:0] se, input logic [4:0] sf,
                       input logic [4:0] sc);
        string ft, ct;
        op_valid = op; exc_raw = raw; report_en = rep;
        sw_wr = sw; sw_enable = se; sw_flags = sf; sw_cause = sc;
        if (sw && op)      begin ft = "R8 flags"; ct = "R8 cause"; end
        else if (sw)       begin ft = "R7 flags"; ct = "R7 cause"; end
        else if (op && rep) begin ft = "R2 flags"; ct = "R3 cause"; end
        else if (op)       begin ft = "R5 flags"; ct = "R5 cause"; end
        else               begin ft = "R9 flags"; ct = "R9 cause"; end
        @(negedge clk);
        chk(ft, flags_q, m_flags);
        chk(ct, cause_q, m_cause);
        chk(sw ? "R7 enable" : "R9 enable", enable_q, m_enable);
        chk("R6 trap", {4'b0, trap_req}, {4'b0, m_trap});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags", flags_q, 5'b0);
        chk("R1 cause", cause_q, 5'b0);
        chk("R1 enable", enable_q, 5'b0);
        chk("R1 trap", {4'b0, trap_req}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after release", flags_q, 5'b0);

        // All enables clear: flags record, cause stays zero
        cyc(1, 5'b11111, 1, 0, 0, 0, 0);
        chk("R2 all flags", flags_q, 5'b11111);
        chk("R3 no enables", cause_q, 5'b00000);
        // R10: lone invalid lands in bit 4
        cyc(1, 5'b10000, 1, 0, 0, 0, 0);
        chk("R10 invalid bit", flags_q, 5'b10000);
        // Enable overflow and inexact only
        cyc(0, 0, 1, 1, 5'b00101, 5'b0, 5'b0);
        chk("R7 enable load", enable_q, 5'b00101);
        cyc(1, 5'b00111, 1, 0, 0, 0, 0);
        chk("R3 partial mask", cause_q, 5'b00101);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R6 trap after cause", {4'b0, trap_req}, 5'b00001);
        // R4: overwrite, not accumulate
        cyc(1, 5'b00001, 1, 0, 0, 0, 0);
        cyc(1, 5'b00100, 1, 0, 0, 0, 0);
        chk("R4 flags overwrite", flags_q, 5'b00100);
        chk("R4 cause overwrite", cause_q, 5'b00100);
        cyc(1, 5'b00010, 1, 0, 0, 0, 0);
        chk("R4 cause to zero", cause_q, 5'b00000);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R6 trap drops", {4'b0, trap_req}, 5'b0);
        // R5: reporting off clears
        cyc(1, 5'b11111, 1, 0, 0, 0, 0);
        cyc(1, 5'b11111, 0, 0, 0, 0, 0);
        chk("R5 flags cleared", flags_q, 5'b0);
        chk("R5 cause cleared", cause_q, 5'b0);
        // R8: collision, software wins
        cyc(1, 5'b11111, 1, 1, 5'b11111, 5'b01010, 5'b00010);
        chk("R8 flags from sw", flags_q, 5'b01010);
        chk("R8 cause from sw", cause_q, 5'b00010);
        // R9: idle holds
        cyc(0, 5'b10101, 1, 0, 5'b0, 5'b0, 5'b0);
        chk("R9 hold flags", flags_q, 5'b01010);

        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 3) != 0, 5'($urandom), ($urandom % 5) != 0,
                ($urandom % 7) == 0, 5'($urandom), 5'($urandom), 5'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule